// File: doc/BRIEF.md
# Flash Lock and Protection Controller

This block guards the destructive operations of a paged flash array. Flash pages are 512 bytes (128 words of 32 bits), and consecutive groups of 32 pages form lock regions, so a 256-page array has 8 regions (16 regions for 512 pages, 32 for 1024). Software issues one command at a time on a plain strobe interface. The commands are program page, erase page, full erase, lock or unlock a region, and set or clear one of four non-volatile option bits. Commands that reach the array are handed to an array stub through a start pulse, and the stub answers with a done pulse. The controller aborts any program or erase aimed at a locked region and flags it.

The four option bits have fixed meanings. Bit 0 is the security bit, bit 1 enables the brownout detector, bit 2 enables brownout reset, and bit 3 selects boot from flash. While security is set, the debug and fast-programming paths are denied. The security bit cannot be cleared by command. It clears only when a full erase completes after the external erase pin has been seen asserted. The erase pin is synchronised and must stay high for a parameterised number of slow-clock ticks. Once that qualification is met, all lock bits and both brownout bits clear, and the security bit becomes clearable.

The command port does not apply back-pressure. A write that arrives while `ready` is low is dropped, and the drop is recorded in `cmd_err`; it is not stalled. `ready` falls for at least one cycle on every accepted command. `irq` pulses for one cycle when `ready` rises, if `irq_en` is high at that moment.

Top module: `flash_guard`

## Requirements
- R1: After reset `ready` is 1, `irq`, `cmd_err`, `lock_err` and `arr_start` are 0, and all lock bits and option bits are 0.
- R2: Opcodes 1 (program page) and 2 (erase page), aimed at an unlocked region, and opcode 3 (full erase) with no region locked, raise `arr_start` for exactly one cycle. At the same time `arr_op` is driven to the opcode and `arr_page` to `cmd_arg`. `ready` stays low until the cycle after `arr_done` is sampled.
- R3: A program or erase-page command whose page (`cmd_arg` / 32) lies in a locked region produces no `arr_start`. `ready` is low for one cycle and `lock_err` is set.
- R4: Opcode 4 sets and opcode 5 clears the lock bit of region `cmd_arg` (its low bits). The change is visible two cycles after the write.
- R5: Opcode 6 sets and opcode 7 clears option bit `cmd_arg[1:0]`.
- R6: An opcode outside 1..7, or any write while `ready` is low, sets `cmd_err` and changes no other state. The next accepted command clears both `cmd_err` and `lock_err`.
- R7: `irq` is a one-cycle pulse in the first cycle of `ready` high after a command, gated by `irq_en`.
- R8: The erase pin, once held high for `DEBOUNCE_TICKS` consecutive slow ticks, clears all lock bits and option bits 1 and 2. Shorter pulses have no effect.
- R9: Option bit 0 ignores the clear command. It clears only when a full erase completes after a qualified erase-pin event.
- R10: Completion of a full erase clears option bit 3. A full erase requested while any region is locked is aborted as in R3.
- R11: `dbg_allow` is high exactly when option bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable marking each slow-clock tick |
| erase_pin | input | 1 | External erase request, asynchronous |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_arg | input | PAGE_W | Page, region or bit index |
| irq_en | input | 1 | Interrupt enable |
| ready | output | 1 | High when no command is running |
| cmd_err | output | 1 | Rejected-write flag |
| lock_err | output | 1 | Locked-target abort flag |
| irq | output | 1 | Command-finished interrupt pulse |
| arr_start | output | 1 | Array operation start pulse |
| arr_op | output | 2 | Array operation: 1 program, 2 page erase, 3 full erase |
| arr_page | output | PAGE_W | Target page for the array |
| arr_done | input | 1 | Array operation finished |
| lock_bits | output | REGIONS | Per-region lock state |
| gp_bits | output | 4 | Option bits |
| dbg_allow | output | 1 | Debug and fast-programming access permitted |

## Verification
The assertions check, on every cycle, the properties that are local in time. These are: the start pulse is single and never overlaps ready, an abort never starts the array, busy writes are flagged, the interrupt coincides with the rising edge of ready under its enable, and the security and boot bits fall only after a full erase completes. Only the bench scenarios can show the ordering-dependent behaviour. That covers the region arithmetic mapping page 70 into locked region 2, the difference between a short and a qualified erase-pin pulse, and the fact that a full erase leaves security set unless the pin event came first. The cycle-level reference model covers every output on every clock.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [3:0] {
    OP_PROG   = 4'h1,
    OP_PERASE = 4'h2,
    OP_FERASE = 4'h3,
    OP_LOCK   = 4'h4,
    OP_UNLOCK = 4'h5,
    OP_GPSET  = 4'h6,
    OP_GPCLR  = 4'h7
  } fg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WRAP = 2'd1,
    ST_ARR  = 2'd2
  } fg_state_e;

  localparam int GP_N      = 4;
  localparam int GP_SEC    = 0;
  localparam int GP_BOD    = 1;
  localparam int GP_BODRST = 2;
  localparam int GP_BOOT   = 3;
  localparam logic [1:0] ARR_FERASE = 2'd3;
endpackage

// File: rtl/flash_guard_debounce.sv
module flash_guard_debounce #(
  parameter int TICKS = 8,
  localparam int CNT_W = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic hit
);
  logic s1, s2, fired;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; fired <= 1'b0; cnt <= '0; hit <= 1'b0;
    end else begin
      s1  <= pin;
      s2  <= s1;
      hit <= 1'b0;
      if (!s2) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (tick && !fired) begin
        if (cnt == CNT_W'(TICKS - 1)) begin
          fired <= 1'b1;
          hit   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_guard_seq.sv
module flash_guard_seq
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int REGIONS   = 8,
  parameter int REG_SHIFT = 5,
  localparam int REG_W    = $clog2(REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [3:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_arg,
  input  logic              irq_en,
  input  logic              arr_done,
  input  logic [REGIONS-1:0] lock_bits,
  output logic              ready,
  output logic              cmd_err,
  output logic              lock_err,
  output logic              irq,
  output logic              arr_start,
  output logic [1:0]        arr_op,
  output logic [PAGE_W-1:0] arr_page,
  output logic              arr_busy,
  output logic              lock_we,
  output logic              lock_val,
  output logic [REG_W-1:0]  lock_idx,
  output logic              gp_we,
  output logic              gp_val,
  output logic [1:0]        gp_idx,
  output logic              ferase_done
);
  fg_state_e        state;
  logic [3:0]       op_q;
  logic [REG_W-1:0] arg_q;
  logic             op_known, is_arr, locked;
  logic [REG_W-1:0] tgt_reg;

  always_comb begin
    op_known = (cmd_op >= 4'h1) && (cmd_op <= 4'h7);
    is_arr   = (cmd_op >= 4'h1) && (cmd_op <= 4'h3);
    tgt_reg  = REG_W'(cmd_arg >> REG_SHIFT);
    locked   = (cmd_op == OP_FERASE) ? (|lock_bits) : lock_bits[tgt_reg];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; op_q <= '0; arg_q <= '0;
      cmd_err <= 1'b0; lock_err <= 1'b0; irq <= 1'b0;
      arr_start <= 1'b0; arr_op <= '0; arr_page <= '0;
    end else begin
      irq       <= 1'b0;
      arr_start <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_wr) begin
          if (!op_known) begin
            cmd_err <= 1'b1;
          end else begin
            cmd_err  <= 1'b0;
            lock_err <= 1'b0;
            op_q     <= cmd_op;
            arg_q    <= cmd_arg[REG_W-1:0];
            if (is_arr && locked) begin
              lock_err <= 1'b1;
              state    <= ST_WRAP;
            end else if (is_arr) begin
              arr_start <= 1'b1;
              arr_op    <= cmd_op[1:0];
              arr_page  <= cmd_arg;
              state     <= ST_ARR;
            end else begin
              state <= ST_WRAP;
            end
          end
        end
        ST_WRAP: begin
          if (cmd_wr) cmd_err <= 1'b1;
          state <= ST_IDLE;
          irq   <= irq_en;
        end
        ST_ARR: begin
          if (cmd_wr) cmd_err <= 1'b1;
          if (arr_done) begin
            state <= ST_IDLE;
            irq   <= irq_en;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ready       = (state == ST_IDLE);
    arr_busy    = (state == ST_ARR);
    lock_we     = (state == ST_WRAP) && (op_q == OP_LOCK || op_q == OP_UNLOCK);
    lock_val    = (op_q == OP_LOCK);
    lock_idx    = arg_q;
    gp_we       = (state == ST_WRAP) && (op_q == OP_GPSET || op_q == OP_GPCLR);
    gp_val      = (op_q == OP_GPSET);
    gp_idx      = arg_q[1:0];
    ferase_done = (state == ST_ARR) && arr_done && (arr_op == ARR_FERASE);
  end
endmodule

// File: rtl/flash_guard_prot.sv
module flash_guard_prot
  import flash_guard_pkg::*;
#(
  parameter int REGIONS = 8,
  localparam int REG_W  = $clog2(REGIONS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_we,
  input  logic               lock_val,
  input  logic [REG_W-1:0]   lock_idx,
  input  logic               gp_we,
  input  logic               gp_val,
  input  logic [1:0]         gp_idx,
  input  logic               ferase_done,
  input  logic               pin_hit,
  output logic [REGIONS-1:0] lock_bits,
  output logic [GP_N-1:0]    gp_bits
);
  logic            armed, armed_n;
  logic [GP_N-1:0] gp_n;

  for (genvar r = 0; r < REGIONS; r++) begin : g_region
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lock_bits[r] <= 1'b0;
      else if (pin_hit)                            lock_bits[r] <= 1'b0;
      else if (lock_we && lock_idx == REG_W'(r))   lock_bits[r] <= lock_val;
    end
  end

  always_comb begin
    gp_n    = gp_bits;
    armed_n = armed;
    if (gp_we && !(gp_idx == 2'(GP_SEC) && !gp_val)) gp_n[gp_idx] = gp_val;
    if (ferase_done) begin
      gp_n[GP_BOOT] = 1'b0;
      if (armed) begin
        gp_n[GP_SEC] = 1'b0;
        armed_n      = 1'b0;
      end
    end
    if (pin_hit) begin
      gp_n[GP_BOD]    = 1'b0;
      gp_n[GP_BODRST] = 1'b0;
      armed_n         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_bits <= '0;
      armed   <= 1'b0;
    end else begin
      gp_bits <= gp_n;
      armed   <= armed_n;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_PAGES        = 256,
  parameter int PAGES_PER_REGION = 32,
  parameter int DEBOUNCE_TICKS   = 8,
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int REGIONS   = NUM_PAGES / PAGES_PER_REGION,
  localparam int REG_W     = $clog2(REGIONS),
  localparam int REG_SHIFT = $clog2(PAGES_PER_REGION)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_tick,
  input  logic               erase_pin,
  input  logic               cmd_wr,
  input  logic [3:0]         cmd_op,
  input  logic [PAGE_W-1:0]  cmd_arg,
  input  logic               irq_en,
  output logic               ready,
  output logic               cmd_err,
  output logic               lock_err,
  output logic               irq,
  output logic               arr_start,
  output logic [1:0]         arr_op,
  output logic [PAGE_W-1:0]  arr_page,
  input  logic               arr_done,
  output logic [REGIONS-1:0] lock_bits,
  output logic [GP_N-1:0]    gp_bits,
  output logic               dbg_allow
);
  logic             pin_hit, arr_busy;
  logic             lock_we, lock_val, gp_we, gp_val, ferase_done;
  logic [REG_W-1:0] lock_idx;
  logic [1:0]       gp_idx;

  flash_guard_debounce #(.TICKS(DEBOUNCE_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .pin(erase_pin), .hit(pin_hit)
  );

  flash_guard_seq #(.PAGE_W(PAGE_W), .REGIONS(REGIONS), .REG_SHIFT(REG_SHIFT)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .irq_en(irq_en), .arr_done(arr_done), .lock_bits(lock_bits),
    .ready(ready), .cmd_err(cmd_err), .lock_err(lock_err), .irq(irq),
    .arr_start(arr_start), .arr_op(arr_op), .arr_page(arr_page), .arr_busy(arr_busy),
    .lock_we(lock_we), .lock_val(lock_val), .lock_idx(lock_idx),
    .gp_we(gp_we), .gp_val(gp_val), .gp_idx(gp_idx), .ferase_done(ferase_done)
  );

  flash_guard_prot #(.REGIONS(REGIONS)) u_prot (
    .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_val(lock_val), .lock_idx(lock_idx),
    .gp_we(gp_we), .gp_val(gp_val), .gp_idx(gp_idx), .ferase_done(ferase_done),
    .pin_hit(pin_hit), .lock_bits(lock_bits), .gp_bits(gp_bits)
  );

  assign dbg_allow = ~gp_bits[GP_SEC];
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       ready,
  input logic       irq,
  input logic       irq_en,
  input logic       arr_start,
  input logic       arr_done,
  input logic [1:0] arr_op,
  input logic       arr_busy,
  input logic       lock_err,
  input logic       cmd_err,
  input logic       sec_bit,
  input logic       boot_bit
);
  p_start_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> !ready);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |=> !arr_start);
  p_abort_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> !arr_start);
  p_busy_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ready) |=> cmd_err);
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ready && !$past(ready)));
  p_irq_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
  p_sec_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_bit) |-> $past(arr_busy && arr_done && arr_op == 2'd3));
  p_boot_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_busy && arr_done && arr_op == 2'd3) |=> !boot_bit);
endmodule

bind flash_guard flash_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .ready(ready), .irq(irq),
  .irq_en(irq_en), .arr_start(arr_start), .arr_done(arr_done), .arr_op(arr_op),
  .arr_busy(arr_busy), .lock_err(lock_err), .cmd_err(cmd_err),
  .sec_bit(gp_bits[0]), .boot_bit(gp_bits[3])
);

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
  localparam int NP = 256, PPR = 32, DB = 8, RG = NP / PPR, PW = 8;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, erase_pin = 1'b0;
  logic cmd_wr = 1'b0, irq_en = 1'b0, arr_done = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [PW-1:0] cmd_arg = '0;
  logic ready, cmd_err, lock_err, irq, arr_start, dbg_allow;
  logic [1:0] arr_op;
  logic [PW-1:0] arr_page;
  logic [RG-1:0] lock_bits;
  logic [3:0] gp_bits;

  int compared = 0, mismatched = 0, cycles = 0, tick_cnt = 0, rcnt = 0;
  bit done_run = 0, live = 0;

  flash_guard u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .erase_pin(erase_pin),
    .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .irq_en(irq_en),
    .ready(ready), .cmd_err(cmd_err), .lock_err(lock_err), .irq(irq),
    .arr_start(arr_start), .arr_op(arr_op), .arr_page(arr_page), .arr_done(arr_done),
    .lock_bits(lock_bits), .gp_bits(gp_bits), .dbg_allow(dbg_allow)
  );

  always #10 clk = ~clk;

  // reference model state
  int m_state = 0, m_op = 0, m_arg = 0, m_aop = 0, m_apage = 0, m_cnt = 0;
  bit m_irq = 0, m_start = 0, m_cerr = 0, m_lerr = 0, m_arm = 0;
  bit m_s1 = 0, m_s2 = 0, m_fired = 0, m_hit = 0;
  logic [RG-1:0] m_lock = '0;
  logic [3:0] m_gp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_op = 0; m_arg = 0; m_aop = 0; m_apage = 0; m_cnt = 0;
      m_irq = 0; m_start = 0; m_cerr = 0; m_lerr = 0; m_arm = 0;
      m_s1 = 0; m_s2 = 0; m_fired = 0; m_hit = 0; m_lock = '0; m_gp = '0;
    end else begin
      int o_state, o_op, o_arg;
      bit o_hit, fd, nh, lk;
      logic [RG-1:0] o_lock;
      o_state = m_state; o_op = m_op; o_arg = m_arg; o_hit = m_hit; o_lock = m_lock;
      fd = (o_state == 2) && arr_done && (m_aop == 3);
      m_irq = 0; m_start = 0;
      case (o_state)
        0: if (cmd_wr) begin
          if (cmd_op < 1 || cmd_op > 7) m_cerr = 1;
          else begin
            m_cerr = 0; m_lerr = 0; m_op = cmd_op; m_arg = cmd_arg;
            if (cmd_op <= 3) begin
              lk = (cmd_op == 3) ? (o_lock != 0) : o_lock[cmd_arg / PPR];
              if (lk) begin m_lerr = 1; m_state = 1; end
              else begin m_start = 1; m_aop = cmd_op; m_apage = cmd_arg; m_state = 2; end
            end else m_state = 1;
          end
        end
        1: begin if (cmd_wr) m_cerr = 1; m_state = 0; m_irq = irq_en; end
        default: begin
          if (cmd_wr) m_cerr = 1;
          if (arr_done) begin m_state = 0; m_irq = irq_en; end
        end
      endcase
      if (o_state == 1) begin
        if (o_op == 4) m_lock[o_arg % RG] = 1'b1;
        if (o_op == 5) m_lock[o_arg % RG] = 1'b0;
        if (o_op == 6) m_gp[o_arg % 4] = 1'b1;
        if (o_op == 7 && (o_arg % 4) != 0) m_gp[o_arg % 4] = 1'b0;
      end
      if (fd) begin
        m_gp[3] = 1'b0;
        if (m_arm) begin m_gp[0] = 1'b0; m_arm = 0; end
      end
      if (o_hit) begin m_lock = '0; m_gp[1] = 1'b0; m_gp[2] = 1'b0; m_arm = 1; end
      nh = 0;
      if (!m_s2) begin m_cnt = 0; m_fired = 0; end
      else if (slow_tick && !m_fired) begin
        if (m_cnt == DB - 1) begin m_fired = 1; nh = 1; end
        else m_cnt++;
      end
      m_hit = nh; m_s2 = m_s1; m_s1 = erase_pin;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (live) begin
      chk(ready == (m_state == 0), "R2 ready", ready, m_state == 0);
      chk(irq == m_irq, "R7 irq", irq, m_irq);
      chk(arr_start == m_start, "R2/R3 arr_start", arr_start, m_start);
      if (m_start) begin
        chk(arr_op == 2'(m_aop), "R2 arr_op", arr_op, m_aop);
        chk(arr_page == PW'(m_apage), "R2 arr_page", arr_page, m_apage);
      end
      chk(lock_bits == m_lock, "R4 lock_bits", lock_bits, m_lock);
      chk(gp_bits == m_gp, "R5 gp_bits", gp_bits, m_gp);
      chk(dbg_allow == !m_gp[0], "R11 dbg_allow", dbg_allow, !m_gp[0]);
      chk(cmd_err == m_cerr, "R6 cmd_err", cmd_err, m_cerr);
      chk(lock_err == m_lerr, "R3 lock_err", lock_err, m_lerr);
    end
  end

  // slow tick and array stub
  always @(negedge clk) begin
    tick_cnt++;
    slow_tick <= (tick_cnt % 4 == 0);
    if (arr_start) begin rcnt = 3; arr_done <= 1'b0; end
    else if (rcnt > 0) begin rcnt--; arr_done <= (rcnt == 0); end
    else arr_done <= 1'b0;
  end

  task automatic issue(input int op, input int arg);
    @(negedge clk);
    cmd_wr <= 1'b1; cmd_op <= 4'(op); cmd_arg <= PW'(arg);
    @(negedge clk);
    cmd_wr <= 1'b0;
    for (int i = 0; i < 50 && !ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pin_pulse(input int len);
    @(negedge clk); erase_pin <= 1'b1;
    repeat (len) @(negedge clk);
    erase_pin <= 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    live = 1;
    chk(ready && !irq && !cmd_err && !lock_err && !arr_start && lock_bits == 0 && gp_bits == 0,
        "R1 reset state", {ready, gp_bits}, 5'h10);
    issue(1, 5);
    chk(lock_err == 0, "R2 program unlocked", lock_err, 0);
    issue(4, 2);
    chk(lock_bits == 8'h04, "R4 lock region 2", lock_bits, 8'h04);
    issue(1, 70);
    chk(lock_err == 1, "R3 program page 70 locked", lock_err, 1);
    issue(2, 64);
    chk(lock_err == 1, "R3 erase page 64 locked", lock_err, 1);
    issue(2, 100);
    chk(lock_err == 0, "R2 erase page 100 unlocked", lock_err, 0);
    issue(3, 0);
    chk(lock_err == 1, "R10 full erase refused while locked", lock_err, 1);
    issue(5, 2);
    chk(lock_bits == 0, "R4 unlock region 2", lock_bits, 0);
    issue(0, 0);
    chk(cmd_err == 1, "R6 opcode 0", cmd_err, 1);
    issue(9, 0);
    chk(cmd_err == 1 && lock_bits == 0 && gp_bits == 0, "R6 opcode 9 no effect", cmd_err, 1);
    issue(6, 1);
    chk(cmd_err == 0 && gp_bits == 4'h2, "R6 cleared by accepted cmd", {cmd_err, gp_bits}, 5'h02);
    // write while busy
    @(negedge clk); cmd_wr <= 1'b1; cmd_op <= 4'h1; cmd_arg <= 8'd9;
    @(negedge clk); cmd_op <= 4'h4; cmd_arg <= 8'd1;
    @(negedge clk); cmd_wr <= 1'b0;
    for (int i = 0; i < 50 && !ready; i++) @(negedge clk);
    @(negedge clk);
    chk(cmd_err == 1 && lock_bits == 0, "R6 busy write dropped", {cmd_err, lock_bits}, 9'h100);
    irq_en <= 1'b1;
    issue(6, 3); issue(6, 0); issue(6, 2);
    chk(gp_bits == 4'hF, "R5 set all option bits", gp_bits, 4'hF);
    chk(dbg_allow == 0, "R11 security denies debug", dbg_allow, 0);
    issue(7, 0);
    chk(gp_bits[0] == 1, "R9 clear command ignored on bit 0", gp_bits[0], 1);
    issue(7, 2); issue(6, 2);
    issue(3, 0);
    chk(gp_bits == 4'h7, "R9 R10 full erase without pin", gp_bits, 4'h7);
    issue(4, 5);
    pin_pulse(12);
    chk(lock_bits == 8'h20 && gp_bits == 4'h7, "R8 short pin ignored", {lock_bits, gp_bits}, 12'h207);
    pin_pulse(60);
    chk(lock_bits == 0 && gp_bits == 4'h1, "R8 qualified pin clears", {lock_bits, gp_bits}, 12'h001);
    issue(3, 0);
    chk(gp_bits == 0 && dbg_allow == 1, "R9 security cleared by erase", {dbg_allow, gp_bits}, 5'h10);
    irq_en <= 1'b0;
    issue(6, 0);
    issue(3, 0);
    chk(gp_bits[0] == 1, "R9 second erase without pin keeps security", gp_bits[0], 1);
    repeat (4) @(negedge clk);
    done_run = 1;
    finish_run();
  end

  initial begin
    for (int i = 0; i < 50000 && !done_run; i++) @(posedge clk);
    if (!done_run) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end
endmodule